// File: doc/BRIEF.md
# Packed-Decimal Add/Subtract Unit

This is a combinational add-with-carry and subtract-with-borrow unit for an 8-bit processor datapath. In binary mode it behaves as a plain ripple adder. Subtraction is done on the same adder: the second operand is inverted and the carry input serves as "not borrow".

When the decimal flag is set, each operand nibble is read as one packed decimal digit. Each digit position first takes the binary sum of its nibbles and the incoming carry, then corrects that sum before its carry passes to the next digit.

- For addition, a digit sum above nine gets six added and sends a carry onward.
- For subtraction, a digit that borrowed gets six removed and sends a borrow onward.

The final carry out of the top digit is the unit's carry-out. The number of digits is a parameter; the default gives the 8-bit width.

Top module: `bcd_addsub_unit`

## Requirements
- R1: With dec_mode=0 and sub_sel=0, {carry_out, sum_out} equals op_a + op_b + carry_in as a 9-bit unsigned sum.
- R2: With dec_mode=0 and sub_sel=1, sum_out equals (op_a - op_b - (1 - carry_in)) mod 256. carry_out is 1 exactly when op_a >= op_b + (1 - carry_in), that is, when no borrow occurs.
- R3: With dec_mode=1 and sub_sel=0, let A and B be the decimal values of the operands, with bits [7:4] as the tens digit and bits [3:0] as the units digit. sum_out holds (A + B + carry_in) mod 100 in the same digit layout, and carry_out is 1 exactly when A + B + carry_in >= 100.
- R4: With dec_mode=1 and sub_sel=1, sum_out holds (A - B - (1 - carry_in)) mod 100 as packed digits, and carry_out is 1 exactly when no borrow leaves the tens digit.
- R5: In decimal mode with every operand nibble in 0..9, every nibble of sum_out is in 0..9.
- R6: In decimal mode, a correction in the units digit passes its carry (add) or borrow (subtract) into the tens digit. For example, 0x09 + 0x00 with carry_in=1 gives 0x10, and 0x10 - 0x01 with carry_in=1 gives 0x09.
- R7: With dec_mode=0, no decimal correction is applied. For example, 0x09 + 0x01 gives 0x0A with carry_out=0.
- R8: The unit has no state. sum_out and carry_out follow the inputs within the same clock cycle, and all-zero inputs give a zero result with carry_out=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 8 | First operand (minuend for subtract) |
| op_b | input | 8 | Second operand (subtrahend for subtract) |
| carry_in | input | 1 | Carry in; acts as not-borrow when subtracting |
| sub_sel | input | 1 | 1 selects subtract, 0 selects add |
| dec_mode | input | 1 | 1 selects packed-decimal arithmetic |
| sum_out | output | 8 | Result |
| carry_out | output | 1 | Carry out; not-borrow when subtracting |

## Verification
Both results are combinational, so each one is due in the same cycle its inputs change, with no register on the path. The bench changes the inputs on a falling clock edge and reads sum_out and carry_out two nanoseconds later, well before the next rising edge. It then compares them with a digit-wise decimal model, or a plain integer model in binary mode. Random decimal operands are drawn one digit at a time in 0..9, so no invalid digit is ever applied.

// File: rtl/bcd_addsub_unit.sv
module bcd_addsub_unit #(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS,
  localparam int LIMIT = 10 ** DIGITS
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         carry_in,
  input  logic         sub_sel,
  input  logic         dec_mode,
  output logic [W-1:0] sum_out,
  output logic         carry_out
);

  logic [DIGITS:0] cy;
  logic [W-1:0]    res;
  logic [3:0]      na, nb;
  logic [4:0]      s;
  logic [W:0]      bin_full;
  logic            in_ok, out_ok;
  int              dv_a, dv_b, dv_r, borrow;

  always_comb begin
    cy[0] = carry_in;
    res   = '0;
    for (int i = 0; i < DIGITS; i++) begin
      na = op_a[4*i +: 4];
      nb = sub_sel ? ~op_b[4*i +: 4] : op_b[4*i +: 4];
      s  = {1'b0, na} + {1'b0, nb} + {4'b0, cy[i]};
      if (dec_mode && !sub_sel && s > 5'd9) begin
        s = s + 5'd6;
        cy[i+1] = 1'b1;
      end else if (dec_mode && sub_sel && !s[4]) begin
        s = s - 5'd6;
        cy[i+1] = 1'b0;
      end else begin
        cy[i+1] = s[4];
      end
      res[4*i +: 4] = s[3:0];
    end

    bin_full = {1'b0, op_a} + {1'b0, (sub_sel ? ~op_b : op_b)} + {{W{1'b0}}, carry_in};
    in_ok  = 1'b1;
    out_ok = 1'b1;
    dv_a = 0; dv_b = 0; dv_r = 0;
    for (int i = DIGITS - 1; i >= 0; i--) begin
      if (op_a[4*i +: 4] > 4'd9 || op_b[4*i +: 4] > 4'd9) in_ok = 1'b0;
      if (res[4*i +: 4] > 4'd9) out_ok = 1'b0;
      dv_a = dv_a * 10 + int'(op_a[4*i +: 4]);
      dv_b = dv_b * 10 + int'(op_b[4*i +: 4]);
      dv_r = dv_r * 10 + int'(res[4*i +: 4]);
    end
    borrow = carry_in ? 0 : 1;

    if (!$isunknown({op_a, op_b, carry_in, sub_sel, dec_mode})) begin
      if (!dec_mode && !sub_sel)
        p_bin_add_r1: assert ({cy[DIGITS], res} == bin_full) else $error("binary add mismatch");
      if (!dec_mode && sub_sel)
        p_bin_sub_r2: assert ({cy[DIGITS], res} == bin_full) else $error("binary subtract mismatch");
      if (dec_mode && in_ok) begin
        p_digits_r5: assert (out_ok) else $error("result digit above nine");
        if (!sub_sel)
          p_dec_add_r3: assert (cy[DIGITS] == (dv_a + dv_b + int'(carry_in) >= LIMIT)
                                && dv_r == (dv_a + dv_b + int'(carry_in)) % LIMIT)
            else $error("decimal add mismatch");
        else
          p_dec_sub_r4: assert (cy[DIGITS] == (dv_a >= dv_b + borrow)
                                && dv_r == (dv_a - dv_b - borrow + LIMIT) % LIMIT)
            else $error("decimal subtract mismatch");
      end
    end
  end

  assign sum_out   = res;
  assign carry_out = cy[DIGITS];

endmodule

// File: tb/test_bcd_addsub_unit.sv
module test_bcd_addsub_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] a = '0, b = '0;
  logic ci = 1'b0, sub = 1'b0, dec = 1'b0;
  logic [7:0] sum;
  logic co;
  int n_checks = 0, n_errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bcd_addsub_unit i_bcd_addsub_unit (
    .op_a(a), .op_b(b), .carry_in(ci), .sub_sel(sub), .dec_mode(dec),
    .sum_out(sum), .carry_out(co)
  );

  function automatic logic [8:0] model(logic [7:0] x, logic [7:0] y, logic c, logic s, logic d);
    int v, dx, dy;
    if (!d) begin
      if (!s) v = int'(x) + int'(y) + int'(c);
      else    v = int'(x) - int'(y) - (c ? 0 : 1);
      if (!s) return v[8:0];
      return {v >= 0, v[7:0]};
    end
    dx = int'(x[7:4]) * 10 + int'(x[3:0]);
    dy = int'(y[7:4]) * 10 + int'(y[3:0]);
    if (!s) begin
      v = dx + dy + int'(c);
      return {v >= 100, 4'((v % 100) / 10), 4'(v % 10)};
    end
    v = dx - dy - (c ? 0 : 1);
    if (v < 0) return {1'b0, 4'((v + 100) / 10), 4'((v + 100) % 10)};
    return {1'b1, 4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic check(logic [7:0] x, logic [7:0] y, logic c, logic s, logic d, string req);
    logic [8:0] exp;
    @(negedge clk);
    a = x; b = y; ci = c; sub = s; dec = d;
    #2;
    exp = model(x, y, c, s, d);
    n_checks++;
    if ({co, sum} !== exp) begin
      n_errors++;
      $display("FAIL %s: a=%h b=%h ci=%b sub=%b dec=%b got co=%b sum=%h expected co=%b sum=%h",
               req, x, y, c, s, d, co, sum, exp[8], exp[7:0]);
    end
    if (d && (sum[7:4] > 4'd9 || sum[3:0] > 4'd9)) begin
      n_errors++;
      $display("FAIL R5: digit above nine, got %h expected digits 0..9", sum);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    check(8'h00, 8'h00, 1'b0, 1'b0, 1'b0, "R8 zero inputs");
    check(8'hFF, 8'h01, 1'b0, 1'b0, 1'b0, "R1 wrap");
    check(8'h00, 8'h01, 1'b1, 1'b1, 1'b0, "R2 borrow");
    check(8'h09, 8'h01, 1'b0, 1'b0, 1'b0, "R7 no correction");
    check(8'h99, 8'h01, 1'b0, 1'b0, 1'b1, "R3 decimal wrap");
    check(8'h99, 8'h99, 1'b1, 1'b0, 1'b1, "R3 max");
    check(8'h00, 8'h01, 1'b1, 1'b1, 1'b1, "R4 decimal borrow");
    check(8'h45, 8'h45, 1'b1, 1'b1, 1'b1, "R4 equal");
    check(8'h00, 8'h00, 1'b0, 1'b1, 1'b1, "R4 borrow in");
    check(8'h09, 8'h00, 1'b1, 1'b0, 1'b1, "R6 carry ripple");
    check(8'h10, 8'h01, 1'b1, 1'b1, 1'b1, "R6 borrow ripple");
    check(8'h58, 8'h46, 1'b0, 1'b0, 1'b1, "R5 digit fix");
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] x, y;
      logic c, s, d;
      c = 1'($urandom); s = 1'($urandom); d = 1'($urandom);
      if (d) begin
        x = {4'($urandom % 10), 4'($urandom % 10)};
        y = {4'($urandom % 10), 4'($urandom % 10)};
      end else begin
        x = 8'($urandom); y = 8'($urandom);
      end
      check(x, y, c, s, d, d ? (s ? "R4 random" : "R3 random") : (s ? "R2 random" : "R1 random"));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule